// File: doc/BRIEF.md
# View-Port Frame Buffer Fetch Address Generator

This block produces the half-word fetch addresses that a display controller needs to pull pixel data out of system memory. The frame buffer sits inside one aligned 4 MB region, which is chosen by a bank number. Inside that region the block walks a view port. On each line it fetches a programmed number of half-words. It then jumps over a programmed gap to the first half-word of the next line, so the visible picture can be a window into a wider virtual screen. It stops when its pointer reaches a programmed end offset.

In dual-scan operation two pointers run at once. One covers the upper half of the panel and the other covers the lower half. Their requests alternate, so both halves fill at the same pace. Each request is a burst of 4 or 8 words, cut short at the end of a line. A request is raised only when the pixel FIFO has room for a full burst. It is held until memory acknowledges it.

The geometry inputs are sampled only while the display is disabled. The pointers reload at every frame-sync pulse from the timing logic.

Top module: `fbag_addr_gen`

## Requirements
- R1: After reset, and until the display is enabled and a frame-sync pulse arrives, `mem_req` is 0.
- R2: The request address is a 32-bit byte address. Bit 31 is 0, bits 30:22 carry the bank, bits 21:1 carry the 21-bit half-word pointer, and bit 0 is 0.
- R3: Each line fetches `cfg_page_width` half-words, starting at the line's first half-word and moving upward. The first fetch of the next line lies `cfg_page_width + cfg_line_skip` half-words above the first fetch of the previous line.
- R4: `mem_len` counts half-words. It equals the smaller of the burst size and the half-words left on the current line. The burst size is 8 half-words (4 words) when `cfg_burst8` is 0 and 16 half-words (8 words) when it is 1.
- R5: With `cfg_dual` at 0, only the upper pointer runs (`mem_lower` = 0). It starts at `cfg_base_upper`. No request is made once the pointer reaches `cfg_base_lower`, which acts as the end offset.
- R6: With `cfg_dual` at 1, the upper pointer runs from `cfg_base_upper` up to `cfg_base_lower`. The lower pointer (`mem_lower` = 1) runs from `cfg_base_lower` up to `2*cfg_base_lower - cfg_base_upper`. The first request of a frame is upper. After that, each request goes to the pointer that was not served last, unless that pointer has finished.
- R7: Geometry inputs are captured only while `disp_en` is 0. Changes made while it is 1 have no effect on the addresses, including the addresses of later frames, until the display is disabled again.
- R8: A request is raised only when `fifo_free` (in words) is at least the burst size in words. Once raised, `mem_req`, `mem_addr` and `mem_len` stay stable until the cycle in which `mem_ack` is 1.
- R9: A frame-sync pulse while enabled drops any outstanding request in the following cycle and restarts both pointers from their bases. Driving `disp_en` to 0 drops `mem_req` in the following cycle.
- R10: With upper base 0x80000, page width 0x50, skip 0x200, 240 lines and end offset 0xA2B00 in single scan with 16-half-word bursts, the frame has exactly 1200 requests and ends exactly at the end offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_en | input | 1 | Display enable; geometry is sampled while 0 |
| frame_sync | input | 1 | Frame start pulse from the timing logic |
| cfg_bank | input | 9 | Address bits 30:22 of the buffer region |
| cfg_base_upper | input | 21 | Upper pointer start, in half-words |
| cfg_base_lower | input | 21 | Single scan: end offset; dual scan: lower pointer start |
| cfg_page_width | input | 11 | Half-words fetched per line |
| cfg_line_skip | input | 11 | Half-words skipped between lines |
| cfg_dual | input | 1 | 1 selects dual scan |
| cfg_burst8 | input | 1 | Burst size: 0 = 4 words, 1 = 8 words |
| fifo_free | input | 5 | Free FIFO space in words |
| mem_req | output | 1 | Burst request |
| mem_addr | output | 32 | Byte address of the burst |
| mem_len | output | 5 | Burst length in half-words |
| mem_lower | output | 1 | 1 when the request comes from the lower pointer |
| mem_ack | input | 1 | Memory accepts the current request |

## Verification
The bench builds the block with its default widths: a 9-bit bank, 21-bit offsets, 11-bit line geometry and a 5-bit FIFO level. It sweeps page widths that sit below, at and across both burst sizes, with and without a line skip, over one and three lines, in both scan modes and both burst sizes. This covers every line-end truncation, the alternation between the upper and lower pointers, and the end-offset stop. The full-width example frame of 240 lines drives the pointer across more than 0x22000 half-words and checks where it stops. Directed cases cover the FIFO threshold, the abort on frame sync, the drop on disable, and geometry written while the display is enabled.

// File: rtl/fbag_pkg.sv
package fbag_pkg;
  localparam int BANK_W    = 9;
  localparam int OFS_W     = 21;
  localparam int PW_W      = 11;
  localparam int ADDR_W    = 1 + BANK_W + OFS_W + 1;
  localparam int WORD_HW   = 2;
  localparam int BURST_LO_W = 4;
  localparam int BURST_HI_W = 8;
  localparam int LEN_W     = $clog2(BURST_HI_W * WORD_HW + 1);
  localparam int N_CTR     = 2;

  typedef struct packed {
    logic [BANK_W-1:0] bank;
    logic [OFS_W-1:0]  base_u;
    logic [OFS_W-1:0]  base_l;
    logic [PW_W-1:0]   pw;
    logic [PW_W-1:0]   skip;
    logic              dual;
    logic              burst8;
  } geom_t;
endpackage

// File: rtl/fbag_geom_latch.sv
module fbag_geom_latch
  import fbag_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  disp_en,
  input  geom_t geom_i,
  output geom_t geom_o
);
  geom_t geom_q;
  logic  cap_en;

  assign cap_en = ~disp_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      geom_q <= '0;
    else if (cap_en) geom_q <= geom_i;
  end

  assign geom_o = geom_q;

  // R7
  geom_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disp_en |=> $stable(geom_q));
endmodule

// File: rtl/fbag_scan_ctr.sv
module fbag_scan_ctr
  import fbag_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             step,
  input  logic [OFS_W-1:0] base_i,
  input  logic [OFS_W-1:0] end_i,
  input  logic [PW_W-1:0]  pw_i,
  input  logic [PW_W-1:0]  skip_i,
  input  logic [LEN_W-1:0] burst_i,
  output logic [OFS_W-1:0] ptr_o,
  output logic [LEN_W-1:0] len_o,
  output logic             active_o
);
  logic [OFS_W-1:0] ptr_q, ptr_d, end_q, end_d;
  logic [PW_W-1:0]  col_q, col_d, left;
  logic             line_end;

  assign left     = pw_i - col_q;
  assign len_o    = (left < PW_W'(burst_i)) ? LEN_W'(left) : burst_i;
  assign line_end = (col_q + PW_W'(len_o)) == pw_i;
  assign active_o = (ptr_q < end_q) && (pw_i != '0);
  assign ptr_o    = ptr_q;

  always_comb begin
    ptr_d = ptr_q;
    col_d = col_q;
    end_d = end_q;
    if (load) begin
      ptr_d = base_i;
      end_d = end_i;
      col_d = '0;
    end else if (step) begin
      if (line_end) begin
        ptr_d = ptr_q + OFS_W'(len_o) + OFS_W'(skip_i);
        col_d = '0;
      end else begin
        ptr_d = ptr_q + OFS_W'(len_o);
        col_d = col_q + PW_W'(len_o);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      end_q <= '0;
      col_q <= '0;
    end else begin
      ptr_q <= ptr_d;
      end_q <= end_d;
      col_q <= col_d;
    end
  end

  // R3
  col_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active_o |-> (col_q < pw_i));
  // R5
  step_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |-> active_o);
endmodule

// File: rtl/fbag_addr_gen.sv
module fbag_addr_gen
  import fbag_pkg::*;
#(
  parameter int FREE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              disp_en,
  input  logic              frame_sync,
  input  logic [BANK_W-1:0] cfg_bank,
  input  logic [OFS_W-1:0]  cfg_base_upper,
  input  logic [OFS_W-1:0]  cfg_base_lower,
  input  logic [PW_W-1:0]   cfg_page_width,
  input  logic [PW_W-1:0]   cfg_line_skip,
  input  logic              cfg_dual,
  input  logic              cfg_burst8,
  input  logic [FREE_W-1:0] fifo_free,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [LEN_W-1:0]  mem_len,
  output logic              mem_lower,
  input  logic              mem_ack
);
  geom_t g_in, g;
  logic [LEN_W-1:0] burst_hw;
  logic [FREE_W-1:0] burst_words;
  logic [OFS_W-1:0] base_v [N_CTR];
  logic [OFS_W-1:0] end_v  [N_CTR];
  logic [OFS_W-1:0] ptr_v  [N_CTR];
  logic [LEN_W-1:0] len_v  [N_CTR];
  logic [N_CTR-1:0] act_raw, act, step_v;
  logic load, room, any_act, pick_lower, served;
  logic pend_q, pend_d, sel_q, sel_d, turn_q, turn_d, armed_q, armed_d;

  assign g_in = '{bank: cfg_bank, base_u: cfg_base_upper, base_l: cfg_base_lower,
                  pw: cfg_page_width, skip: cfg_line_skip,
                  dual: cfg_dual, burst8: cfg_burst8};

  fbag_geom_latch u_geom (
    .clk(clk), .rst_n(rst_n), .disp_en(disp_en), .geom_i(g_in), .geom_o(g)
  );

  assign burst_hw    = g.burst8 ? LEN_W'(BURST_HI_W * WORD_HW) : LEN_W'(BURST_LO_W * WORD_HW);
  assign burst_words = g.burst8 ? FREE_W'(BURST_HI_W) : FREE_W'(BURST_LO_W);
  assign load        = frame_sync & disp_en;

  assign base_v[0] = g.base_u;
  assign end_v[0]  = g.base_l;
  assign base_v[1] = g.base_l;
  assign end_v[1]  = g.base_l + (g.base_l - g.base_u);

  for (genvar i = 0; i < N_CTR; i++) begin : g_ctr
    fbag_scan_ctr u_ctr (
      .clk(clk), .rst_n(rst_n), .load(load), .step(step_v[i]),
      .base_i(base_v[i]), .end_i(end_v[i]), .pw_i(g.pw), .skip_i(g.skip),
      .burst_i(burst_hw), .ptr_o(ptr_v[i]), .len_o(len_v[i]), .active_o(act_raw[i])
    );
    assign step_v[i] = served & (sel_q == (i != 0));
  end

  assign act[0]     = act_raw[0] & armed_q;
  assign act[1]     = act_raw[1] & armed_q & g.dual;
  assign any_act    = |act;
  assign pick_lower = act[1] & (turn_q | ~act[0]);
  assign room       = fifo_free >= burst_words;
  assign served     = pend_q & mem_ack;

  always_comb begin
    armed_d = armed_q;
    if (!disp_en)  armed_d = 1'b0;
    else if (load) armed_d = 1'b1;

    sel_d = pend_q ? sel_q : pick_lower;

    turn_d = turn_q;
    if (load)        turn_d = 1'b0;
    else if (served) turn_d = ~sel_q;

    if (!disp_en || frame_sync) pend_d = 1'b0;
    else if (pend_q)            pend_d = ~mem_ack;
    else                        pend_d = any_act & room;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      sel_q   <= 1'b0;
      turn_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      pend_q  <= pend_d;
      sel_q   <= sel_d;
      turn_q  <= turn_d;
      armed_q <= armed_d;
    end
  end

  assign mem_req   = pend_q;
  assign mem_lower = sel_q;
  assign mem_len   = sel_q ? len_v[1] : len_v[0];
  assign mem_addr  = {1'b0, g.bank, (sel_q ? ptr_v[1] : ptr_v[0]), 1'b0};

  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack && disp_en && !frame_sync) |=>
      (mem_req && $stable(mem_addr) && $stable(mem_len)));
  // R4
  len_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_len != '0 && mem_len <= burst_hw));
  // R9
  disable_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!disp_en || frame_sync) |=> !mem_req);
  // R2
  addr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (!mem_addr[0] && !mem_addr[ADDR_W-1]));
endmodule

// File: tb/fbag_addr_gen_tb.sv
module fbag_addr_gen_tb;
  import fbag_pkg::*;

  logic clk = 1'b0;
  logic rst_n, disp_en, frame_sync, cfg_dual, cfg_burst8, mem_ack;
  logic [BANK_W-1:0] cfg_bank;
  logic [OFS_W-1:0]  cfg_base_upper, cfg_base_lower;
  logic [PW_W-1:0]   cfg_page_width, cfg_line_skip;
  logic [4:0]        fifo_free;
  logic              mem_req, mem_lower;
  logic [ADDR_W-1:0] mem_addr;
  logic [LEN_W-1:0]  mem_len;

  int checks = 0;
  int errors = 0;

  int e_ofs [4096];
  int e_len [4096];
  bit e_low [4096];
  int e_n;
  int s_ofs [2][2048];
  int s_len [2][2048];
  int s_n   [2];

  always #10 clk = ~clk;

  fbag_addr_gen u_dut (
    .clk(clk), .rst_n(rst_n), .disp_en(disp_en), .frame_sync(frame_sync),
    .cfg_bank(cfg_bank), .cfg_base_upper(cfg_base_upper), .cfg_base_lower(cfg_base_lower),
    .cfg_page_width(cfg_page_width), .cfg_line_skip(cfg_line_skip),
    .cfg_dual(cfg_dual), .cfg_burst8(cfg_burst8), .fifo_free(fifo_free),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_len(mem_len),
    .mem_lower(mem_lower), .mem_ack(mem_ack)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Expected stream from R3/R4 per pointer, merged by the R6 alternation rule
  task automatic build(input int bu, input int pw, input int sk, input int lines,
                       input bit dual, input bit b8);
    int bh;
    int iu;
    int il;
    bit turn;
    bit pl;
    bh = b8 ? 16 : 8;
    for (int c = 0; c < 2; c++) begin
      int base;
      base = (c == 0) ? bu : bu + (pw + sk) * lines;
      s_n[c] = 0;
      for (int l = 0; l < lines; l++) begin
        int col;
        col = 0;
        while (col < pw) begin
          int ln;
          ln = (pw - col < bh) ? pw - col : bh;
          s_ofs[c][s_n[c]] = base + l * (pw + sk) + col;
          s_len[c][s_n[c]] = ln;
          s_n[c]++;
          col += ln;
        end
      end
    end
    if (!dual) s_n[1] = 0;
    e_n = 0; iu = 0; il = 0; turn = 0;
    while (iu < s_n[0] || il < s_n[1]) begin
      pl = (il < s_n[1]) && (turn || iu >= s_n[0]);
      if (pl) begin
        e_ofs[e_n] = s_ofs[1][il]; e_len[e_n] = s_len[1][il]; il++;
      end else begin
        e_ofs[e_n] = s_ofs[0][iu]; e_len[e_n] = s_len[0][iu]; iu++;
      end
      e_low[e_n] = pl;
      e_n++;
      turn = !pl;
    end
  endtask

  task automatic setup(input int bank, input int bu, input int bl, input int pw,
                       input int sk, input bit dual, input bit b8);
    @(negedge clk);
    disp_en = 1'b0;
    cfg_bank = BANK_W'(bank); cfg_base_upper = OFS_W'(bu); cfg_base_lower = OFS_W'(bl);
    cfg_page_width = PW_W'(pw); cfg_line_skip = PW_W'(sk);
    cfg_dual = dual; cfg_burst8 = b8;
    repeat (2) @(negedge clk);
    disp_en = 1'b1;
  endtask

  task automatic pulse_sync();
    @(negedge clk);
    frame_sync = 1'b1;
    @(negedge clk);
    frame_sync = 1'b0;
  endtask

  // Acknowledge every request, check it against the expected list, then check the stop
  task automatic serve(input int bank, input string tag);
    int got;
    int idle;
    got = 0; idle = 0;
    while (idle < 12) begin
      @(negedge clk);
      mem_ack = 1'b0;
      if (mem_req) begin
        idle = 0;
        if (got >= e_n) begin
          chk(1'b0, {tag, " R5 extra request"}, longint'(mem_addr), 0);
        end else begin
          chk(mem_addr == {1'b0, BANK_W'(bank), OFS_W'(e_ofs[got]), 1'b0},
              {tag, " R2 R3 addr"}, longint'(mem_addr),
              longint'({1'b0, BANK_W'(bank), OFS_W'(e_ofs[got]), 1'b0}));
          chk(int'(mem_len) == e_len[got], {tag, " R4 len"}, longint'(mem_len), e_len[got]);
          chk(mem_lower == e_low[got], {tag, " R6 source"}, longint'(mem_lower), e_low[got]);
        end
        mem_ack = 1'b1;
        got++;
      end else begin
        idle++;
      end
    end
    mem_ack = 1'b0;
    chk(got == e_n, {tag, " R5 R6 request count"}, got, e_n);
  endtask

  task automatic frame(input int bank, input int bu, input int pw, input int sk,
                       input int lines, input bit dual, input bit b8, input string tag);
    build(bu, pw, sk, lines, dual, b8);
    setup(bank, bu, bu + (pw + sk) * lines, pw, sk, dual, b8);
    pulse_sync();
    serve(bank, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int pws [6];
    pws = '{1, 3, 8, 9, 16, 21};
    rst_n = 1'b0; disp_en = 1'b0; frame_sync = 1'b0; mem_ack = 1'b0;
    cfg_bank = '0; cfg_base_upper = '0; cfg_base_lower = '0;
    cfg_page_width = '0; cfg_line_skip = '0; cfg_dual = 1'b0; cfg_burst8 = 1'b0;
    fifo_free = 5'd31;
    repeat (3) @(negedge clk);
    chk(mem_req == 1'b0, "R1 req in reset", mem_req, 0);
    rst_n = 1'b1;
    setup(9'h31, 'h100, 'h200, 8, 0, 0, 0);
    repeat (6) @(negedge clk);
    chk(mem_req == 1'b0, "R1 no req before frame sync", mem_req, 0);

    // sweep over geometry, scan mode and burst size
    for (int p = 0; p < 6; p++)
      for (int s = 0; s < 2; s++)
        for (int ln = 1; ln <= 3; ln += 2)
          for (int d = 0; d < 2; d++)
            for (int b = 0; b < 2; b++)
              frame(9'h100 + p * 37 + b, 'h1000 * (p + 1) + s * 3, pws[p], s * 7, ln,
                    d[0], b[0], "sweep");

    // R10 full-size frame with the end offset given literally
    build('h80000, 'h50, 'h200, 240, 0, 1);
    setup(9'h31, 'h80000, 'hA2B00, 'h50, 'h200, 0, 1);
    pulse_sync();
    serve(9'h31, "R10 example");
    chk(e_n == 1200, "R10 burst count", e_n, 1200);

    // R8 FIFO threshold: 7 free words below an 8-word burst
    build('h2000, 16, 0, 1, 0, 1);
    setup(9'h5, 'h2000, 'h2010, 16, 0, 0, 1);
    fifo_free = 5'd7;
    pulse_sync();
    repeat (8) @(negedge clk);
    chk(mem_req == 1'b0, "R8 no req below threshold", mem_req, 0);
    fifo_free = 5'd8;
    repeat (2) @(negedge clk);
    chk(mem_req == 1'b1, "R8 req at threshold", mem_req, 1);
    fifo_free = 5'd0;
    repeat (3) @(negedge clk);
    chk(mem_req == 1'b1 && mem_addr == {1'b0, 9'h5, 21'h2000, 1'b0},
        "R8 held without ack", longint'(mem_addr), longint'({1'b0, 9'h5, 21'h2000, 1'b0}));
    fifo_free = 5'd31;
    serve(9'h5, "R8 after release");

    // R9 abort on frame sync, then restart from the base
    build('h3000, 12, 4, 2, 1, 0);
    setup(9'h7, 'h3000, 'h3000 + 16 * 2, 12, 4, 1, 0);
    pulse_sync();
    @(negedge clk);
    chk(mem_req == 1'b1, "R9 request pending", mem_req, 1);
    frame_sync = 1'b1;
    @(negedge clk);
    frame_sync = 1'b0;
    chk(mem_req == 1'b0, "R9 dropped by frame sync", mem_req, 0);
    serve(9'h7, "R9 restart");

    // R9 disable drops the request
    pulse_sync();
    @(negedge clk);
    disp_en = 1'b0;
    @(negedge clk);
    chk(mem_req == 1'b0, "R9 dropped by disable", mem_req, 0);

    // R7 geometry written while enabled is ignored, also for the next frame
    build('h4000, 9, 2, 2, 0, 1);
    setup(9'h1A, 'h4000, 'h4000 + 11 * 2, 9, 2, 0, 1);
    @(negedge clk);
    cfg_bank = 9'h0F; cfg_base_upper = 'h7000; cfg_base_lower = 'h7100;
    cfg_page_width = 5; cfg_line_skip = 1; cfg_dual = 1'b1; cfg_burst8 = 1'b0;
    pulse_sync();
    serve(9'h1A, "R7 first frame");
    pulse_sync();
    serve(9'h1A, "R7 second frame");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule